// File: doc/BRIEF.md
# Smart-Card Half-Duplex Serial Port

This block moves bytes over a single shared open-drain wire, the kind of link a contact smart card uses. Every character on the wire is one low start bit, eight payload bits, one parity bit and a high stop bit. The block only ever pulls the wire low. A logic one is sent by releasing the wire, and an external pull-up holds it high.

Transmit and receive watch the same wire. With both halves enabled, the receiver captures every character the transmitter sends. When the receiver finds a parity mismatch, it answers by holding the wire low for the whole stop slot of that character. The transmitter samples the wire in the middle of its own stop slot, so the sending side learns that the far end rejected the character. A programmable divider sets the bit rate. Single-cycle request flags tell the surrounding logic that a character has finished in either direction.

Top module: `sc_uart`

## Requirements
- R1: A character on the wire is a low start slot, eight payload slots, a parity slot, and a high (released) stop slot, in that order. When idle, `line_drive_low` is 0.
- R2: One bit slot lasts 16 × (`baud_div` + 1) count-clock periods. `clk_sel` picks the count clock: 0 = every `clk`, 1 = every 2nd, 2 = every 8th, 3 = every 32nd, 4..7 = each rising edge of `ext_tick`.
- R3: With `inv_fmt` = 0, payload slot k carries data bit k (bit 0 first) without inversion. The parity slot carries the XOR of the eight data bits (even parity).
- R4: With `inv_fmt` = 1, payload slot k carries the inverse of data bit 7−k (bit 7 first). The parity slot carries the inverse of the XOR of the data bits. The receiver decodes and checks with the same convention.
- R5: `tx_buf_empty` goes low the cycle after `tb_wr`. It goes high again when the byte moves into the shifter, which happens only while `tx_en` = 1.
- R6: `tx_shift_empty` is low while a character is on the wire and high once its stop slot has ended.
- R7: `tx_irq` sets when a transmitted character completes, and `rx_irq` sets when a received one is stored. Each stays set until its acknowledge input is pulsed.
- R8: On a received character, the block places the decoded byte on `rb_data`, places the parity result on `rb_perr` (1 = mismatch), and sets `rx_full`. A `rb_rd` pulse clears `rx_full`.
- R9: When the parity of a received character mismatches, the receiver drives the wire low for that character's stop slot. When the parity matches, the receiver does not drive the wire.
- R10: The transmitter samples the wire at the middle of its stop slot. It sets `tx_err_seen` if the wire is low, and clears the flag when the next character is loaded.
- R11: A low on the wire shorter than half a bit slot does not start a reception.
- R12: With both halves enabled, the receiver captures the block's own transmission and returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Count-clock select |
| ext_tick | input | 1 | External count clock (rising edges counted) |
| baud_div | input | 8 | Divider value n |
| inv_fmt | input | 1 | 1 = inverse format, 0 = direct format |
| tx_en | input | 1 | Allow transmit loads |
| rx_en | input | 1 | Allow reception starts |
| tb_wr | input | 1 | Write strobe for the transmit buffer |
| tb_data | input | 8 | Byte to send |
| rb_rd | input | 1 | Read strobe for the receive buffer |
| rb_data | output | 8 | Last received byte |
| rb_perr | output | 1 | Parity mismatch of the last received byte |
| line_i | input | 1 | Sensed wire level |
| line_drive_low | output | 1 | 1 = pull the wire low |
| tx_buf_empty | output | 1 | Transmit buffer free |
| tx_shift_empty | output | 1 | Transmit shifter idle |
| tx_err_seen | output | 1 | Wire found low in the last stop slot |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| tx_irq | output | 1 | Transmit completion request |
| rx_irq | output | 1 | Receive completion request |
| tx_irq_ack | input | 1 | Clears `tx_irq` |
| rx_irq_ack | input | 1 | Clears `rx_irq` |

## Verification
The bench acts as the card. It drives characters with correct and corrupted parity, and it pulls the wire low inside the block's stop slot. A receiver that judged parity with the wrong convention, or placed its error pulse in the wrong slot, would either stay silent on a bad character or pull the wire on a good one. A transmitter that sampled too early would miss the pulse. The bench measures slot length in clocks for three count-clock choices, including the external one, which exposes an off-by-one in the divider reload. It also sends a short glitch and a byte held back by a disabled transmitter, which expose a receiver that starts without mid-bit qualification and a load that ignores the enable.

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int DW   = 8,
  parameter int OSR  = 16,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      clk_sel,
  input  logic            ext_tick,
  input  logic [DIVW-1:0] baud_div,
  input  logic            inv_fmt,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic            tb_wr,
  input  logic [DW-1:0]   tb_data,
  input  logic            rb_rd,
  output logic [DW-1:0]   rb_data,
  output logic            rb_perr,
  input  logic            line_i,
  output logic            line_drive_low,
  output logic            tx_buf_empty,
  output logic            tx_shift_empty,
  output logic            tx_err_seen,
  output logic            rx_full,
  output logic            tx_irq,
  output logic            rx_irq,
  input  logic            tx_irq_ack,
  input  logic            rx_irq_ack
);
  localparam int FRAME = DW + 3;
  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(FRAME);
  localparam logic [SW-1:0] SUB_MID  = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] SUB_CHK  = SW'(OSR / 2);
  localparam logic [SW-1:0] SUB_END  = SW'(OSR - 1);
  localparam logic [BW-1:0] BIT_PAR  = BW'(FRAME - 2);
  localparam logic [BW-1:0] BIT_STOP = BW'(FRAME - 1);
  localparam logic          DW_ODD   = 1'(DW % 2);

  function automatic logic [DW:0] encode(input logic [DW-1:0] d, input logic inv);
    logic [DW:0] r;
    for (int i = 0; i < DW; i++) r[i] = inv ? ~d[DW-1-i] : d[i];
    r[DW] = inv ? ~(^d) : (^d);
    return r;
  endfunction

  function automatic logic [DW-1:0] decode(input logic [DW:0] raw, input logic inv);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = inv ? ~raw[DW-1-i] : raw[i];
    return r;
  endfunction

  // count clock and bit-rate divider
  logic [4:0]      pre_q;
  logic            ext_q, cnt_en, tick;
  logic [DIVW-1:0] brg_q;

  always_comb begin
    case (clk_sel)
      3'd0:    cnt_en = 1'b1;
      3'd1:    cnt_en = pre_q[0];
      3'd2:    cnt_en = &pre_q[2:0];
      3'd3:    cnt_en = &pre_q;
      default: cnt_en = ext_tick & ~ext_q;
    endcase
  end

  assign tick = cnt_en && (brg_q >= baud_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ext_q <= 1'b0;
      brg_q <= '0;
    end else begin
      pre_q <= pre_q + 5'd1;
      ext_q <= ext_tick;
      if (cnt_en) brg_q <= tick ? '0 : brg_q + DIVW'(1);
    end
  end

  logic [1:0] line_s;
  logic       line_q;
  assign line_q = line_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_s <= 2'b11;
    else        line_s <= {line_s[0], line_i};
  end

  // transmitter
  logic          tb_full, tx_busy, tx_out;
  logic [DW-1:0] tb_q;
  logic [SW-1:0] tx_sub;
  logic [BW-1:0] tx_bit;
  logic [DW+1:0] tx_sh;
  logic          tx_load, tx_last;

  assign tx_load = tick && !tx_busy && tb_full && tx_en;
  assign tx_last = tick && tx_busy && tx_sub == SUB_END && tx_bit == BIT_STOP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_full     <= 1'b0;
      tb_q        <= '0;
      tx_busy     <= 1'b0;
      tx_out      <= 1'b1;
      tx_sub      <= '0;
      tx_bit      <= '0;
      tx_sh       <= '1;
      tx_err_seen <= 1'b0;
      tx_irq      <= 1'b0;
    end else begin
      if (tb_wr) begin
        tb_q    <= tb_data;
        tb_full <= 1'b1;
      end else if (tx_load) begin
        tb_full <= 1'b0;
      end
      if (tx_load) begin
        tx_busy     <= 1'b1;
        tx_out      <= 1'b0;
        tx_sub      <= '0;
        tx_bit      <= '0;
        tx_sh       <= {1'b1, encode(tb_q, inv_fmt)};
        tx_err_seen <= 1'b0;
      end else if (tick && tx_busy) begin
        if (tx_sub == SUB_CHK && tx_bit == BIT_STOP) tx_err_seen <= ~line_q;
        if (tx_sub == SUB_END) begin
          tx_sub <= '0;
          if (tx_bit == BIT_STOP) begin
            tx_busy <= 1'b0;
            tx_out  <= 1'b1;
          end else begin
            tx_bit <= tx_bit + BW'(1);
            tx_out <= tx_sh[0];
            tx_sh  <= {1'b1, tx_sh[DW+1:1]};
          end
        end else begin
          tx_sub <= tx_sub + SW'(1);
        end
      end
      if (tx_last)         tx_irq <= 1'b1;
      else if (tx_irq_ack) tx_irq <= 1'b0;
    end
  end

  // receiver
  logic          rx_busy, rx_drv;
  logic [SW-1:0] rx_sub;
  logic [BW-1:0] rx_bit;
  logic [DW:0]   rx_sh;
  logic          rx_perr_c, rx_mid, rx_end, rx_done;

  assign rx_perr_c = (^rx_sh) ^ (inv_fmt & ~DW_ODD);
  assign rx_mid    = tick && rx_busy && rx_sub == SUB_MID;
  assign rx_end    = tick && rx_busy && rx_sub == SUB_END;
  assign rx_done   = rx_end && rx_bit == BIT_STOP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_drv  <= 1'b0;
      rx_sub  <= '0;
      rx_bit  <= '0;
      rx_sh   <= '0;
      rb_data <= '0;
      rb_perr <= 1'b0;
      rx_full <= 1'b0;
      rx_irq  <= 1'b0;
    end else begin
      if (!rx_busy) begin
        if (tick && rx_en && !line_q) begin
          rx_busy <= 1'b1;
          rx_sub  <= '0;
          rx_bit  <= '0;
        end
      end else if (tick) begin
        rx_sub <= (rx_sub == SUB_END) ? '0 : rx_sub + SW'(1);
        if (rx_mid) begin
          if (rx_bit == '0) begin
            if (line_q) rx_busy <= 1'b0;
          end else if (rx_bit != BIT_STOP) begin
            rx_sh <= {line_q, rx_sh[DW:1]};
          end
        end
        if (rx_end) begin
          rx_bit <= rx_bit + BW'(1);
          if (rx_bit == BIT_PAR) rx_drv <= rx_perr_c;
          if (rx_bit == BIT_STOP) begin
            rx_busy <= 1'b0;
            rx_drv  <= 1'b0;
            rb_data <= decode(rx_sh, inv_fmt);
            rb_perr <= rx_perr_c;
          end
        end
      end
      if (rx_done)    rx_full <= 1'b1;
      else if (rb_rd) rx_full <= 1'b0;
      if (rx_done)         rx_irq <= 1'b1;
      else if (rx_irq_ack) rx_irq <= 1'b0;
    end
  end

  assign line_drive_low = (tx_busy & ~tx_out) | rx_drv;
  assign tx_buf_empty   = ~tb_full;
  assign tx_shift_empty = ~tx_busy;

  AST_START_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_shift_empty) |-> line_drive_low); // R1
  AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    tb_wr |=> !tx_buf_empty); // R5
  AST_TX_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_shift_empty) |-> tx_irq); // R7
  AST_RX_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rb_rd) |=> rx_full); // R8
  AST_ERR_PULSE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drv |-> rx_busy); // R9
endmodule

// File: tb/sc_uart_tb.sv
module sc_uart_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] clk_sel = 3'd0;
  logic       ext_tick;
  logic [7:0] baud_div = 8'd0;
  logic       inv_fmt = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic       tb_wr = 1'b0, rb_rd = 1'b0;
  logic [7:0] tb_data = 8'd0;
  logic [7:0] rb_data;
  logic       rb_perr, line_i, line_drive_low;
  logic       tx_buf_empty, tx_shift_empty, tx_err_seen, rx_full, tx_irq, rx_irq;
  logic       tx_irq_ack = 1'b0, rx_irq_ack = 1'b0;
  logic       card_low = 1'b0;

  int ecnt = 0;
  always @(posedge clk) ecnt <= (ecnt == 2) ? 0 : ecnt + 1;
  assign ext_tick = (ecnt == 0);
  assign line_i = ~(line_drive_low | card_low);

  sc_uart u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .baud_div(baud_div), .inv_fmt(inv_fmt), .tx_en(tx_en), .rx_en(rx_en),
    .tb_wr(tb_wr), .tb_data(tb_data), .rb_rd(rb_rd), .rb_data(rb_data),
    .rb_perr(rb_perr), .line_i(line_i), .line_drive_low(line_drive_low),
    .tx_buf_empty(tx_buf_empty), .tx_shift_empty(tx_shift_empty),
    .tx_err_seen(tx_err_seen), .rx_full(rx_full), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .tx_irq_ack(tx_irq_ack), .rx_irq_ack(rx_irq_ack)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic inv);
    logic [10:0] f;
    int ones = 0;
    f[0] = 1'b0;
    for (int k = 0; k < 8; k++) f[k+1] = inv ? !d[7-k] : d[k];
    for (int k = 0; k < 8; k++) ones += int'(d[k]);
    f[9] = (ones % 2 == 1) ^ inv;
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic wait_until(input int which, input int limit);
    int g = 0;
    while (g < limit) begin
      if (which == 0 && line_drive_low) break;
      if (which == 1 && rx_full) break;
      if (which == 2 && tx_shift_empty) break;
      if (which == 3 && !tx_shift_empty) break;
      @(negedge clk);
      g++;
    end
  endtask

  task automatic capture(input int T, output logic [10:0] f);
    wait_until(0, 6000);
    repeat (T / 2) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      f[k] = line_i;
      if (k < 10) repeat (T) @(negedge clk);
    end
  endtask

  task automatic clear_all();
    rb_rd = 1'b1; tx_irq_ack = 1'b1; rx_irq_ack = 1'b1;
    @(negedge clk);
    rb_rd = 1'b0; tx_irq_ack = 1'b0; rx_irq_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, input logic inv, input string tag);
    logic [10:0] f;
    inv_fmt = inv;
    tb_data = d; tb_wr = 1'b1;
    fork
      begin
        @(negedge clk); tb_wr = 1'b0;
        chk({"R5 buffer busy after write ", tag}, int'(tx_buf_empty), 0);
        @(negedge clk);
        chk({"R5 buffer free after load ", tag}, int'(tx_buf_empty), 1);
        chk({"R6 shifter busy ", tag}, int'(tx_shift_empty), 0);
      end
      capture(16, f);
    join
    chk({inv ? "R4" : "R3", " R1 wire frame ", tag}, int'(f), int'(exp_frame(d, inv)));
    wait_until(1, 400);
    chk({"R12 loopback byte ", tag}, int'(rb_data), int'(d));
    chk({"R8 parity ok ", tag}, int'(rb_perr), 0);
    chk({"R9 no echo pulse ", tag}, int'(tx_err_seen), 0);
    chk({"R6 shifter idle ", tag}, int'(tx_shift_empty), 1);
    chk({"R7 tx request ", tag}, int'(tx_irq), 1);
    chk({"R7 rx request ", tag}, int'(rx_irq), 1);
    clear_all();
    chk({"R8 read clears full ", tag}, int'(rx_full), 0);
    chk({"R7 ack clears requests ", tag}, int'(tx_irq | rx_irq), 0);
  endtask

  task automatic measure(input logic [2:0] sel, input logic [7:0] n, input int exp_clk);
    int cnt = 0;
    clk_sel = sel; baud_div = n; inv_fmt = 1'b0;
    @(negedge clk);
    tb_data = 8'h00; tb_wr = 1'b1;
    @(negedge clk); tb_wr = 1'b0;
    wait_until(0, 6000);
    while (line_drive_low && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R2 ten low slots length", cnt, exp_clk);
    wait_until(1, 6000);
    wait_until(2, 6000);
    clear_all();
  endtask

  task automatic card_send(input logic [7:0] d, input logic bad);
    logic [10:0] f;
    logic drv_mid = 1'b0;
    f = exp_frame(d, 1'b0);
    if (bad) f[9] = ~f[9];
    for (int k = 0; k < 11; k++) begin
      card_low = ~f[k];
      if (k == 10) begin
        repeat (8) @(negedge clk);
        drv_mid = line_drive_low;
        repeat (8) @(negedge clk);
      end else begin
        repeat (16) @(negedge clk);
      end
    end
    card_low = 1'b0;
    chk(bad ? "R9 error pulse in stop slot" : "R9 silent on good parity", int'(drv_mid), int'(bad));
    repeat (40) @(negedge clk);
    chk("R8 card byte stored", int'(rx_full), 1);
    chk("R8 card byte value", int'(rb_data), int'(d));
    chk("R8 parity status", int'(rb_perr), int'(bad));
    chk("R7 rx request from card", int'(rx_irq), 1);
    clear_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset buffer empty", int'(tx_buf_empty), 1);
    chk("R6 reset shifter idle", int'(tx_shift_empty), 1);
    chk("R8 reset no data", int'(rx_full), 0);
    chk("R1 reset wire released", int'(line_drive_low), 0);
    chk("R7 reset no requests", int'(tx_irq | rx_irq), 0);

    tx_en = 1'b1; rx_en = 1'b1;
    @(negedge clk);
    xfer(8'hA5, 1'b0, "A5 direct");
    xfer(8'h07, 1'b0, "07 direct");
    xfer(8'h3A, 1'b1, "3A inverse");
    xfer(8'hC1, 1'b1, "C1 inverse");

    measure(3'd2, 8'd2, 3840);
    measure(3'd1, 8'd4, 1600);
    measure(3'd4, 8'd1, 960);
    clk_sel = 3'd0; baud_div = 8'd0;

    tx_en = 1'b0;
    repeat (4) @(negedge clk);
    card_send(8'h5C, 1'b0);
    card_send(8'h5C, 1'b1);
    card_send(8'h81, 1'b1);

    card_low = 1'b1;
    repeat (4) @(negedge clk);
    card_low = 1'b0;
    repeat (300) @(negedge clk);
    chk("R11 glitch ignored full", int'(rx_full), 0);
    chk("R11 glitch ignored request", int'(rx_irq), 0);

    rx_en = 1'b0; tx_en = 1'b1; inv_fmt = 1'b0;
    tb_data = 8'h55; tb_wr = 1'b1;
    @(negedge clk); tb_wr = 1'b0;
    wait_until(0, 200);
    repeat (160) @(negedge clk);
    card_low = 1'b1;
    repeat (16) @(negedge clk);
    card_low = 1'b0;
    wait_until(2, 200);
    chk("R10 sender sees pulled stop slot", int'(tx_err_seen), 1);
    clear_all();
    tb_data = 8'h55; tb_wr = 1'b1;
    @(negedge clk); tb_wr = 1'b0;
    @(negedge clk);
    chk("R10 error flag cleared on load", int'(tx_err_seen), 0);
    wait_until(2, 400);
    chk("R10 clean stop slot", int'(tx_err_seen), 0);
    clear_all();

    tx_en = 1'b0;
    tb_data = 8'h12; tb_wr = 1'b1;
    @(negedge clk); tb_wr = 1'b0;
    repeat (60) @(negedge clk);
    chk("R5 held while disabled buffer", int'(tx_buf_empty), 0);
    chk("R5 held while disabled shifter", int'(tx_shift_empty), 1);
    chk("R5 held while disabled wire", int'(line_drive_low), 0);
    tx_en = 1'b1;
    wait_until(3, 50);
    chk("R5 load after enable", int'(tx_buf_empty), 1);
    wait_until(2, 400);
    chk("R6 idle after enabled frame", int'(tx_shift_empty), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule